// File: doc/BRIEF.md
# Video Sync Slave Timing Decoder

This block sits at the front of a video encoder. When the encoder follows timing from outside, it turns the sync lines it receives into events: a one-clock line-start pulse, a one-clock frame-start pulse and an odd/even field flag. It also produces an active-video enable. Two bits choose one of four conventions for deciding which sync edges begin a new field. The enable comes either from an external active-low blanking input or, when that input is switched off, from an internal count of the lines since the last frame start.

In master operation the decoder ignores the external sync lines. It drives three sync pins from horizontal, vertical and field flags made elsewhere in the encoder. The block does not count lines or fields for master operation.

All sync inputs pass through one register stage. Edges are found by comparing that stage with the stage before it. A setting is held in a small configuration register that is loaded by a write strobe.

Top module: `vsd_top`

## Requirements
- R1: After reset the configuration is slave, mode 0, external blanking off. The outputs frame_start, line_start, field_odd and active_en are 0, and hs_out, blank_out and fv_out are 1.
- R2: In slave operation, a falling edge on hs_in gives a one-clock line_start pulse. The pulse is seen two rising clock edges after the input change. A rising edge on hs_in gives no pulse, and neither does a steady level.
- R3: Mode 0 (cfg_mode_in = 0): every change of fv_in gives a frame_start pulse with the same timing as R2. On that pulse field_odd becomes 1 if fv_in is now low and 0 if it is high.
- R4: Mode 1: a change of fv_in while the sampled hs_in is low gives a frame_start pulse, with field_odd set as in R3. A change while hs_in is high is ignored, and field_odd keeps its value.
- R5: Mode 2: a falling edge of fv_in in the same sample as a falling edge of hs_in gives frame_start with field_odd = 1. A falling edge of fv_in while hs_in is high gives frame_start with field_odd = 0. A fall of fv_in while hs_in is already low is ignored, and so is any rise of fv_in.
- R6: Mode 3: a change of fv_in while the sampled hs_in is high gives a frame_start pulse, with field_odd set as in R3. A change while hs_in is low is ignored.
- R7: With external blanking off, a frame start clears a line counter and each line start adds one to it. active_en is 1 only when the count is at least BLANK_LINES. The count saturates at 2^LINE_W-1 and does not wrap.
- R8: With external blanking on, active_en equals blank_n_in delayed by one clock, whatever the line count is.
- R9: In master operation, hs_out, blank_out and fv_out equal int_h, int_v and int_f delayed by one clock, and no frame_start or line_start pulses occur. In slave operation all three pins are held at 1.
- R10: The configuration changes only on a clock edge where cfg_we is 1. When cfg_we is 0, the config inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Loads the configuration register |
| cfg_master_in | input | 1 | 1 = master operation, 0 = slave |
| cfg_mode_in | input | 2 | Sync convention, 0 to 3 |
| cfg_blank_en_in | input | 1 | 1 = use the external blanking input |
| hs_in | input | 1 | External horizontal sync, active low |
| fv_in | input | 1 | External field or vertical sync |
| blank_n_in | input | 1 | External active-video enable, low = blanked |
| int_h | input | 1 | Internal horizontal flag for master operation |
| int_v | input | 1 | Internal vertical flag for master operation |
| int_f | input | 1 | Internal field flag for master operation |
| hs_out | output | 1 | Horizontal sync pin drive |
| blank_out | output | 1 | Blanking pin drive |
| fv_out | output | 1 | Field/vertical pin drive |
| field_odd | output | 1 | 1 during an odd field |
| frame_start | output | 1 | One-clock pulse at a detected field start |
| line_start | output | 1 | One-clock pulse at a detected line start |
| active_en | output | 1 | Active-video enable |

## Verification
The bench builds the block with LINE_W = 4 and BLANK_LINES = 3. With these values the threshold that ends internal blanking is crossed after only a few lines, and the saturation limit of 15 is reached within twenty lines, so the no-wrap behaviour can be observed on active_en. In each of the four modes the bench steps through every pair of old and new sampled values of hs_in and fv_in. This covers every edge combination behind the field rules. Master operation is checked with all eight patterns of the internal flags.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

  typedef enum logic [1:0] {
    TM_FLAGS       = 2'd0,
    TM_FIELD_HLOW  = 2'd1,
    TM_HV_PAIR     = 2'd2,
    TM_FIELD_HHIGH = 2'd3
  } tmode_e;

  typedef struct packed {
    logic hs_lvl;
    logic fv_lvl;
    logic hs_fall;
    logic fv_fall;
    logic fv_flip;
  } sync_view_t;

  typedef struct packed {
    logic vstart;
    logic odd;
    logic lstart;
  } decode_t;

  // Field/line start rules for each sync convention
  function automatic decode_t decode_rule(input tmode_e m, input sync_view_t s);
    decode_t d;
    d.lstart = s.hs_fall;
    d.odd    = ~s.fv_lvl;
    d.vstart = 1'b0;
    case (m)
      TM_FLAGS:      d.vstart = s.fv_flip;
      TM_FIELD_HLOW: d.vstart = s.fv_flip & ~s.hs_lvl;
      TM_HV_PAIR: begin
        d.vstart = s.fv_fall & (s.hs_fall | s.hs_lvl);
        d.odd    = s.hs_fall;
      end
      default:       d.vstart = s.fv_flip & s.hs_lvl;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/vsd_sync_sampler.sv
module vsd_sync_sampler
  import vsd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hs_in,
  input  logic       fv_in,
  input  logic       blank_n_in,
  output sync_view_t view,
  output logic       blank_n_q
);

  logic hs_q, hs_p, fv_q, fv_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q      <= 1'b1;
      hs_p      <= 1'b1;
      fv_q      <= 1'b1;
      fv_p      <= 1'b1;
      blank_n_q <= 1'b0;
    end else begin
      hs_q      <= hs_in;
      hs_p      <= hs_q;
      fv_q      <= fv_in;
      fv_p      <= fv_q;
      blank_n_q <= blank_n_in;
    end
  end

  assign view.hs_lvl  = hs_q;
  assign view.fv_lvl  = fv_q;
  assign view.hs_fall = hs_p & ~hs_q;
  assign view.fv_fall = fv_p & ~fv_q;
  assign view.fv_flip = fv_p ^ fv_q;

  // R2: a falling edge seen once cannot be seen again on the next sample
  a_r2_fall_once: assert property (@(posedge clk) disable iff (!rst_n)
    view.hs_fall |=> !view.hs_fall);

endmodule

// File: rtl/vsd_line_blank.sv
module vsd_line_blank #(
  parameter int LINE_W      = 10,
  parameter int BLANK_LINES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  input  logic ext_sel,
  input  logic ext_blank_n,
  output logic active
);

  localparam logic [LINE_W-1:0] CNT_MAX = '1;
  localparam logic [LINE_W-1:0] BL_LIM  = LINE_W'(BLANK_LINES);

  logic [LINE_W-1:0] cnt;
  logic              int_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (clr)                    cnt <= '0;
    else if (inc && cnt != CNT_MAX)  cnt <= cnt + LINE_W'(1);
  end

  assign int_active = (cnt >= BL_LIM);
  assign active     = ext_sel ? ext_blank_n : int_active;

  // R7: without a clear, internal enable never drops back (saturation, no wrap)
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !ext_sel && !clr) |=> (active || ext_sel));

endmodule

// File: rtl/vsd_top.sv
module vsd_top
  import vsd_pkg::*;
#(
  parameter int LINE_W      = 10,
  parameter int BLANK_LINES = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_master_in,
  input  logic [1:0] cfg_mode_in,
  input  logic       cfg_blank_en_in,
  input  logic       hs_in,
  input  logic       fv_in,
  input  logic       blank_n_in,
  input  logic       int_h,
  input  logic       int_v,
  input  logic       int_f,
  output logic       hs_out,
  output logic       blank_out,
  output logic       fv_out,
  output logic       field_odd,
  output logic       frame_start,
  output logic       line_start,
  output logic       active_en
);

  logic       cfg_master;
  tmode_e     cfg_mode;
  logic       cfg_blank_en;
  sync_view_t view;
  logic       blank_n_q;
  decode_t    dec_raw;
  logic       ev_frame, ev_line;

  // Configuration register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_master   <= 1'b0;
      cfg_mode     <= TM_FLAGS;
      cfg_blank_en <= 1'b0;
    end else if (cfg_we) begin
      cfg_master   <= cfg_master_in;
      cfg_mode     <= tmode_e'(cfg_mode_in);
      cfg_blank_en <= cfg_blank_en_in;
    end
  end

  vsd_sync_sampler u_smp (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_in     (hs_in),
    .fv_in     (fv_in),
    .blank_n_in(blank_n_in),
    .view      (view),
    .blank_n_q (blank_n_q)
  );

  assign dec_raw  = decode_rule(cfg_mode, view);
  assign ev_frame = dec_raw.vstart & ~cfg_master;
  assign ev_line  = dec_raw.lstart & ~cfg_master;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_start <= 1'b0;
      line_start  <= 1'b0;
      field_odd   <= 1'b0;
    end else begin
      frame_start <= ev_frame;
      line_start  <= ev_line;
      if (ev_frame) field_odd <= dec_raw.odd;
    end
  end

  // Pin drive: internal flags in master, idle high in slave
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_out    <= 1'b1;
      blank_out <= 1'b1;
      fv_out    <= 1'b1;
    end else begin
      hs_out    <= cfg_master ? int_h : 1'b1;
      blank_out <= cfg_master ? int_v : 1'b1;
      fv_out    <= cfg_master ? int_f : 1'b1;
    end
  end

  vsd_line_blank #(.LINE_W(LINE_W), .BLANK_LINES(BLANK_LINES)) u_lb (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (ev_frame),
    .inc        (ev_line),
    .ext_sel    (cfg_blank_en),
    .ext_blank_n(blank_n_q),
    .active     (active_en)
  );

  // R9: master pins carry the internal flags one clock later
  a_r9_pins_follow: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_master) |-> (hs_out == $past(int_h) && blank_out == $past(int_v)
                           && fv_out == $past(int_f)));

  // R9: slave pins idle high
  a_r9_slave_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_master) |-> (hs_out && blank_out && fv_out));

  // R9: no decoded events in master operation
  a_r9_master_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_master) |-> (!frame_start && !line_start));

  if (BLANK_LINES > 0) begin : g_blank_chk
    // R7: a frame start always leaves the internal enable blanked
    a_r7_frame_blanks: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !cfg_blank_en) |-> !active_en);
  end

endmodule

// File: tb/vsd_top_test.sv
module vsd_top_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_master_in = 0, cfg_blank_en_in = 0;
  logic [1:0] cfg_mode_in = 2'd0;
  logic hs = 1'b1, fv = 1'b1, blank_n = 1'b1;
  logic ih = 0, iv = 0, iff_ = 0;
  logic hs_out, blank_out, fv_out, field_odd, frame_start, line_start, active_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int mode_cur = 0;
  logic cur_h = 1'b1, cur_f = 1'b1;
  logic exp_field = 1'b0;

  always #4 clk = ~clk;

  vsd_top #(.LINE_W(4), .BLANK_LINES(3)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_master_in(cfg_master_in),
    .cfg_mode_in(cfg_mode_in), .cfg_blank_en_in(cfg_blank_en_in),
    .hs_in(hs), .fv_in(fv), .blank_n_in(blank_n),
    .int_h(ih), .int_v(iv), .int_f(iff_),
    .hs_out(hs_out), .blank_out(blank_out), .fv_out(fv_out),
    .field_odd(field_odd), .frame_start(frame_start), .line_start(line_start),
    .active_en(active_en)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R3 mode0";
      1: return "R4 mode1";
      2: return "R5 mode2";
      default: return "R6 mode3";
    endcase
  endfunction

  task automatic set_cfg(input logic m, input int md, input logic be);
    cfg_master_in = m; cfg_mode_in = 2'(md); cfg_blank_en_in = be; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk); @(negedge clk);
    mode_cur = md;
  endtask

  // Expected field-start outcome from the requirements
  task automatic model(input int m, input logic hp, input logic fp, input logic h,
                       input logic f, output logic ev, output logic odd);
    logic hfall, ffall, flip;
    hfall = hp & ~h; ffall = fp & ~f; flip = fp ^ f;
    ev = 1'b0; odd = ~f;
    case (m)
      0: ev = flip;
      1: ev = flip & ~h;
      2: begin
        if (ffall && hfall) begin ev = 1'b1; odd = 1'b1; end
        else if (ffall && h) begin ev = 1'b1; odd = 1'b0; end
      end
      default: ev = flip & h;
    endcase
  endtask

  task automatic move(input logic h, input logic f);
    logic ev, odd, lst;
    model(mode_cur, cur_h, cur_f, h, f, ev, odd);
    lst = cur_h & ~h;
    if (ev) exp_field = odd;
    hs = h; fv = f; cur_h = h; cur_f = f;
    @(negedge clk); @(negedge clk);
    check(frame_start == ev, mode_tag(mode_cur), frame_start, ev);
    check(field_odd == exp_field, {mode_tag(mode_cur), " field"}, field_odd, exp_field);
    check(line_start == lst, "R2 line pulse", line_start, lst);
    @(negedge clk);
    check(!frame_start && !line_start, "R2 pulse width", {frame_start, line_start}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(frame_start == 0 && line_start == 0, "R1 pulses", {frame_start, line_start}, 0);
    check(field_odd == 0, "R1 field", field_odd, 0);
    check(active_en == 0, "R1 active", active_en, 0);
    check({hs_out, blank_out, fv_out} == 3'b111, "R1 pins", {hs_out, blank_out, fv_out}, 7);

    // R2..R6 sweep of every sampled transition in each mode
    for (int m = 0; m < 4; m++) begin
      set_cfg(1'b0, m, 1'b0);
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++) begin
          move(a[1], a[0]);
          move(b[1], b[0]);
        end
    end

    // R7 internal blanking and saturation
    set_cfg(1'b0, 0, 1'b0);
    move(1'b1, 1'b1);
    move(1'b1, 1'b0);
    check(active_en == 0, "R7 after frame", active_en, 0);
    for (int k = 1; k <= 20; k++) begin
      move(1'b0, 1'b0);
      check(active_en == (k >= 3), "R7 line count", active_en, (k >= 3));
      move(1'b1, 1'b0);
    end
    move(1'b1, 1'b1);
    check(active_en == 0, "R7 reblank", active_en, 0);

    // R8 external blanking overrides the count (count is 0 here)
    set_cfg(1'b0, 0, 1'b1);
    blank_n = 1'b1;
    @(negedge clk);
    check(active_en == 1, "R8 ext high", active_en, 1);
    blank_n = 1'b0;
    @(negedge clk);
    check(active_en == 0, "R8 ext low", active_en, 0);
    blank_n = 1'b1;
    @(negedge clk);
    check(active_en == 1, "R8 ext back", active_en, 1);

    // R10 no load without the strobe
    cfg_master_in = 1'b1; ih = 0; iv = 0; iff_ = 0;
    repeat (3) @(negedge clk);
    check({hs_out, blank_out, fv_out} == 3'b111, "R10 no strobe",
          {hs_out, blank_out, fv_out}, 7);

    // R9 master pass-through
    set_cfg(1'b1, 0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      ih = i[2]; iv = i[1]; iff_ = i[0];
      @(negedge clk);
      check({hs_out, blank_out, fv_out} == 3'(i), "R9 pins", {hs_out, blank_out, fv_out}, i);
    end
    hs = 1'b0; fv = 1'b0;
    @(negedge clk); @(negedge clk);
    check(!line_start && !frame_start, "R9 quiet", {frame_start, line_start}, 0);
    hs = 1'b1; fv = 1'b1; cur_h = 1'b1; cur_f = 1'b1;
    repeat (3) @(negedge clk);
    set_cfg(1'b0, 0, 1'b0);
    check({hs_out, blank_out, fv_out} == 3'b111, "R9 slave idle",
          {hs_out, blank_out, fv_out}, 7);
    move(1'b0, 1'b1);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule